// File: doc/BRIEF.md
# Dual-Lane Broadcast Register Load Unit

This block is the write side of a two-lane data register file. Lane X is the explicitly named lane and lane Y is the complementary lane. Each lane holds sixteen 32-bit registers. Register-load requests come from two address-generator ports, the data-memory (DM) port and the program-memory (PM) port, and both may be active in the same cycle. Each request carries an access kind, a 3-bit index-register selector within its generator's bank, a modifier, a destination register number, the loaded word, and the word read from the complementary memory location.

The X-lane register named by a data-register load always receives the loaded word. The Y lane is written in two cases. A broadcast bit is set for the port and the load goes through that port's designated index register; the Y register of the same number then receives the identical word. Otherwise, if the SIMD bit is set, the Y register receives the complementary word. The broadcast and SIMD bits are separate, and broadcast takes precedence whenever it qualifies. Each access post-modifies its index register exactly once. Index registers can be loaded directly, and a read port returns any register or index value for checking.

Top module: `bcast_load_unit`

## Requirements
- R1: Reset clears all 32 data registers, all 16 index registers and the three mode bits (DM broadcast, PM broadcast, SIMD).
- R2: A DM or PM request with `op` = 0 (data-register load) writes its word into X-lane register `dest`. The new value is readable on the read port from the cycle after the clock edge that accepts it.
- R3: With the DM broadcast bit set, a DM data-register load whose `dm_idx` = 1 (index register 1) writes the same word into Y register `dest`. With the PM broadcast bit set, a PM load whose `pm_idx` = 1 (index register 9) does the same.
- R4: Each broadcast bit acts only on its own port and only on that port's designated index register. With SIMD off, any other load leaves lane Y unchanged.
- R5: Requests with `op` = 1 (system-register load), 2 (register store) or 3 (reserved) write neither lane.
- R6: With SIMD on, a data-register load that does not qualify for broadcast writes its complementary word into Y register `dest`. A qualifying broadcast load writes the identical word, whatever the SIMD bit is.
- R7: When the DM and PM ports both issue loads in one cycle, each load is broadcast or not on its own port's rule.
- R8: Every valid access adds its 32-bit modifier, modulo 2^32, to its index register exactly once. A broadcast adds no second step. The DM port uses index registers 0-7 and the PM port uses index registers 8-15.
- R9: When both ports issue data-register loads to the same `dest` in one cycle, `collide` is high in that cycle. In each lane that both loads write, the DM word is stored.
- R10: `idx_we` loads index register `idx_wsel` with `idx_wdata`. If an access post-modifies the same index register in that cycle, the direct load takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load the three mode bits |
| mode_bc_dm | input | 1 | DM-port broadcast enable value |
| mode_bc_pm | input | 1 | PM-port broadcast enable value |
| mode_simd | input | 1 | SIMD enable value |
| idx_we | input | 1 | Direct index-register write |
| idx_wsel | input | 4 | Index register to write (bit 3 selects PM bank) |
| idx_wdata | input | 32 | Index write value |
| dm_valid | input | 1 | DM request valid |
| dm_op | input | 2 | DM access kind (0 RF load, 1 system load, 2 store, 3 reserved) |
| dm_idx | input | 3 | DM index register selector (0-7) |
| dm_mod | input | 32 | DM post-modify amount |
| dm_dest | input | 4 | DM destination register |
| dm_data | input | 32 | DM loaded word |
| dm_ydata | input | 32 | DM complementary word (SIMD) |
| pm_valid | input | 1 | PM request valid |
| pm_op | input | 2 | PM access kind |
| pm_idx | input | 3 | PM index selector (register 8 + value) |
| pm_mod | input | 32 | PM post-modify amount |
| pm_dest | input | 4 | PM destination register |
| pm_data | input | 32 | PM loaded word |
| pm_ydata | input | 32 | PM complementary word (SIMD) |
| rd_lane | input | 1 | Read lane (0 X, 1 Y) |
| rd_addr | input | 4 | Read register number |
| rd_data | output | 32 | Read value |
| idx_rsel | input | 4 | Index register to read |
| idx_rdata | output | 32 | Index read value |
| collide | output | 1 | Both ports load the same register this cycle |

## Verification
A broadcast qualifier that is stuck or mis-decoded makes a Y register hold the wrong word, or a stale one, one cycle after the load. The bench reads back both lanes at the destination for that reason. An index bank that steps twice, or that loses to a post-modify when a direct write arrives in the same cycle, shows a wrong `idx_rdata` on the very next read. A priority fault in the register write appears only when both ports hit the same register, so collision cases are compared lane by lane.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  typedef enum logic [1:0] {
    OP_RF_LOAD  = 2'd0,
    OP_SYS_LOAD = 2'd1,
    OP_STORE    = 2'd2,
    OP_RSVD     = 2'd3
  } ld_op_e;

  function automatic logic writes_rf(input logic valid, input ld_op_e op);
    return valid && (op == OP_RF_LOAD);
  endfunction
endpackage

// File: rtl/bcl_port_qual.sv
module bcl_port_qual
  import bcl_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned SW     = 3,
  parameter int unsigned BC_SEL = 1
) (
  input  logic          valid,
  input  ld_op_e        op,
  input  logic [SW-1:0] idx,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] ydata,
  input  logic          bc_en,
  input  logic          simd_en,
  output logic          x_we,
  output logic          y_we,
  output logic          bc_hit,
  output logic [DW-1:0] y_data
);
  localparam logic [SW-1:0] SEL = SW'(BC_SEL);

  logic rf_load;

  always_comb begin
    rf_load = writes_rf(valid, op);
    bc_hit  = rf_load && bc_en && (idx == SEL);
    x_we    = rf_load;
    y_we    = bc_hit || (rf_load && simd_en);
    y_data  = bc_hit ? data : ydata;
  end
endmodule

// File: rtl/bcl_lane_rf.sv
module bcl_lane_rf #(
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [RW-1:0] addr_a,
  input  logic [DW-1:0] d_a,
  input  logic          we_b,
  input  logic [RW-1:0] addr_b,
  input  logic [DW-1:0] d_b,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << RW;

  logic [DEPTH-1:0][DW-1:0] regs;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    // port a (DM) wins over port b (PM) on the same entry
    always_ff @(posedge clk) begin
      if (!rst_n)                               regs[e] <= '0;
      else if (we_a && addr_a == RW'(e))        regs[e] <= d_a;
      else if (we_b && addr_b == RW'(e))        regs[e] <= d_b;
    end
  end

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/bcl_index_bank.sv
module bcl_index_bank #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_v,
  input  logic [SW-1:0]             acc_sel,
  input  logic [DW-1:0]             acc_mod,
  input  logic                      wr_en,
  input  logic [SW-1:0]             wr_sel,
  input  logic [DW-1:0]             wr_data,
  output logic [(1<<SW)-1:0][DW-1:0] ix
);
  localparam int unsigned NIDX = 1 << SW;

  function automatic logic [DW-1:0] post_mod(input logic [DW-1:0] base,
                                             input logic [DW-1:0] step);
    return base + step;
  endfunction

  for (genvar k = 0; k < NIDX; k++) begin : g_ix
    always_ff @(posedge clk) begin
      if (!rst_n)                               ix[k] <= '0;
      else if (wr_en && wr_sel == SW'(k))       ix[k] <= wr_data;
      else if (acc_v && acc_sel == SW'(k))      ix[k] <= post_mod(ix[k], acc_mod);
    end
  end
endmodule

// File: rtl/bcast_load_unit.sv
module bcast_load_unit
  import bcl_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned RW        = 4,
  parameter int unsigned SW        = 3,
  parameter int unsigned BC_DM_SEL = 1,
  parameter int unsigned BC_PM_SEL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic          mode_bc_dm,
  input  logic          mode_bc_pm,
  input  logic          mode_simd,
  input  logic          idx_we,
  input  logic [SW:0]   idx_wsel,
  input  logic [DW-1:0] idx_wdata,
  input  logic          dm_valid,
  input  logic [1:0]    dm_op,
  input  logic [SW-1:0] dm_idx,
  input  logic [DW-1:0] dm_mod,
  input  logic [RW-1:0] dm_dest,
  input  logic [DW-1:0] dm_data,
  input  logic [DW-1:0] dm_ydata,
  input  logic          pm_valid,
  input  logic [1:0]    pm_op,
  input  logic [SW-1:0] pm_idx,
  input  logic [DW-1:0] pm_mod,
  input  logic [RW-1:0] pm_dest,
  input  logic [DW-1:0] pm_data,
  input  logic [DW-1:0] pm_ydata,
  input  logic          rd_lane,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [SW:0]   idx_rsel,
  output logic [DW-1:0] idx_rdata,
  output logic          collide
);
  localparam int unsigned NPORT = 2;
  localparam int unsigned NLANE = 2;
  localparam int unsigned NIDX  = 1 << SW;

  // mode state
  logic bc_dm_q, bc_pm_q, simd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_dm_q <= 1'b0;
      bc_pm_q <= 1'b0;
      simd_q  <= 1'b0;
    end else if (mode_we) begin
      bc_dm_q <= mode_bc_dm;
      bc_pm_q <= mode_bc_pm;
      simd_q  <= mode_simd;
    end
  end

  // per-port qualification (index 0 = DM, 1 = PM)
  logic   [NPORT-1:0]         p_valid, p_bc, p_xwe, p_ywe, p_hit;
  ld_op_e                     p_op   [NPORT];
  logic   [NPORT-1:0][SW-1:0] p_idx;
  logic   [NPORT-1:0][DW-1:0] p_data, p_ydin, p_ydat;
  logic   [NPORT-1:0][RW-1:0] p_dest;

  assign p_valid = {pm_valid, dm_valid};
  assign p_op[0] = ld_op_e'(dm_op);
  assign p_op[1] = ld_op_e'(pm_op);
  assign p_idx   = {pm_idx, dm_idx};
  assign p_data  = {pm_data, dm_data};
  assign p_ydin  = {pm_ydata, dm_ydata};
  assign p_dest  = {pm_dest, dm_dest};
  assign p_bc    = {bc_pm_q, bc_dm_q};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bcl_port_qual #(
      .DW(DW), .SW(SW), .BC_SEL(p == 0 ? BC_DM_SEL : BC_PM_SEL)
    ) u_qual (
      .valid  (p_valid[p]),
      .op     (p_op[p]),
      .idx    (p_idx[p]),
      .data   (p_data[p]),
      .ydata  (p_ydin[p]),
      .bc_en  (p_bc[p]),
      .simd_en(simd_q),
      .x_we   (p_xwe[p]),
      .y_we   (p_ywe[p]),
      .bc_hit (p_hit[p]),
      .y_data (p_ydat[p])
    );
  end

  // named events for the checker
  logic          dm_xwe, dm_ywe, pm_xwe, pm_ywe, dm_bc, pm_bc;
  logic [DW-1:0] dm_ydat, pm_ydat;
  assign dm_xwe  = p_xwe[0];
  assign dm_ywe  = p_ywe[0];
  assign dm_bc   = p_hit[0];
  assign dm_ydat = p_ydat[0];
  assign pm_xwe  = p_xwe[1];
  assign pm_ywe  = p_ywe[1];
  assign pm_bc   = p_hit[1];
  assign pm_ydat = p_ydat[1];

  assign collide = dm_xwe && pm_xwe && (dm_dest == pm_dest);

  // register-file lanes (index 0 = X, 1 = Y)
  logic [NLANE-1:0]         l_wa, l_wb;
  logic [NLANE-1:0][DW-1:0] l_da, l_db, l_rd;
  assign l_wa = {dm_ywe, dm_xwe};
  assign l_wb = {pm_ywe, pm_xwe};
  assign l_da = {dm_ydat, dm_data};
  assign l_db = {pm_ydat, pm_data};

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    bcl_lane_rf #(.DW(DW), .RW(RW)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_a   (l_wa[l]),
      .addr_a (dm_dest),
      .d_a    (l_da[l]),
      .we_b   (l_wb[l]),
      .addr_b (pm_dest),
      .d_b    (l_db[l]),
      .rd_addr(rd_addr),
      .rd_data(l_rd[l])
    );
  end

  assign rd_data = l_rd[rd_lane];

  // index banks: DM uses the low bank, PM the high bank
  logic [NIDX-1:0][DW-1:0] dm_ix, pm_ix;

  bcl_index_bank #(.DW(DW), .SW(SW)) u_ix_dm (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_v  (dm_valid),
    .acc_sel(dm_idx),
    .acc_mod(dm_mod),
    .wr_en  (idx_we && !idx_wsel[SW]),
    .wr_sel (idx_wsel[SW-1:0]),
    .wr_data(idx_wdata),
    .ix     (dm_ix)
  );

  bcl_index_bank #(.DW(DW), .SW(SW)) u_ix_pm (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_v  (pm_valid),
    .acc_sel(pm_idx),
    .acc_mod(pm_mod),
    .wr_en  (idx_we && idx_wsel[SW]),
    .wr_sel (idx_wsel[SW-1:0]),
    .wr_data(idx_wdata),
    .ix     (pm_ix)
  );

  assign idx_rdata = idx_rsel[SW] ? pm_ix[idx_rsel[SW-1:0]] : dm_ix[idx_rsel[SW-1:0]];
endmodule

// File: rtl/bcl_checker.sv
module bcl_checker #(
  parameter int unsigned DW        = 32,
  parameter int unsigned RW        = 4,
  parameter int unsigned SW        = 3,
  parameter int unsigned BC_DM_SEL = 1,
  parameter int unsigned BC_PM_SEL = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       dm_valid,
  input logic [1:0]                 dm_op,
  input logic [SW-1:0]              dm_idx,
  input logic [DW-1:0]              dm_mod,
  input logic [RW-1:0]              dm_dest,
  input logic [DW-1:0]              dm_data,
  input logic                       pm_valid,
  input logic [1:0]                 pm_op,
  input logic [SW-1:0]              pm_idx,
  input logic [RW-1:0]              pm_dest,
  input logic [DW-1:0]              pm_data,
  input logic                       idx_we,
  input logic [SW:0]                idx_wsel,
  input logic                       collide,
  input logic                       dm_xwe,
  input logic                       dm_ywe,
  input logic [DW-1:0]              dm_ydat,
  input logic                       pm_xwe,
  input logic                       pm_ywe,
  input logic [DW-1:0]              pm_ydat,
  input logic                       bc_dm_q,
  input logic                       bc_pm_q,
  input logic                       simd_q,
  input logic [(1<<SW)-1:0][DW-1:0] dm_ix
);
  localparam logic [SW-1:0] DSEL = SW'(BC_DM_SEL);
  localparam logic [SW-1:0] PSEL = SW'(BC_PM_SEL);

  assert_dm_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_ywe && bc_dm_q && dm_idx == DSEL) |-> dm_ydat == dm_data);
  assert_pm_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_ywe && bc_pm_q && pm_idx == PSEL) |-> pm_ydat == pm_data);
  assert_y_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_ywe && !simd_q) |-> (bc_dm_q && dm_idx == DSEL));
  assert_only_rf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid && dm_op != 2'd0) || (pm_valid && pm_op != 2'd0)
    |-> !((dm_valid && dm_op != 2'd0 && (dm_xwe || dm_ywe)) ||
          (pm_valid && pm_op != 2'd0 && (pm_xwe || pm_ywe))));
  assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> (dm_valid && pm_valid && dm_op == 2'd0 && pm_op == 2'd0 && dm_dest == pm_dest));

  // single post-modify: capture expectation, compare one cycle later
  logic          pend_q;
  logic [SW-1:0] pend_sel_q;
  logic [DW-1:0] pend_exp_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_sel_q <= '0;
      pend_exp_q <= '0;
    end else begin
      pend_q     <= dm_valid && !(idx_we && !idx_wsel[SW] && idx_wsel[SW-1:0] == dm_idx);
      pend_sel_q <= dm_idx;
      pend_exp_q <= dm_ix[dm_idx] + dm_mod;
    end
  end

  assert_postmod_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> dm_ix[pend_sel_q] == pend_exp_q);
endmodule

bind bcast_load_unit bcl_checker #(
  .DW(DW), .RW(RW), .SW(SW), .BC_DM_SEL(BC_DM_SEL), .BC_PM_SEL(BC_PM_SEL)
) u_bcl_checker (
  .clk(clk), .rst_n(rst_n),
  .dm_valid(dm_valid), .dm_op(dm_op), .dm_idx(dm_idx), .dm_mod(dm_mod),
  .dm_dest(dm_dest), .dm_data(dm_data),
  .pm_valid(pm_valid), .pm_op(pm_op), .pm_idx(pm_idx),
  .pm_dest(pm_dest), .pm_data(pm_data),
  .idx_we(idx_we), .idx_wsel(idx_wsel), .collide(collide),
  .dm_xwe(dm_xwe), .dm_ywe(dm_ywe), .dm_ydat(dm_ydat),
  .pm_xwe(pm_xwe), .pm_ywe(pm_ywe), .pm_ydat(pm_ydat),
  .bc_dm_q(bc_dm_q), .bc_pm_q(bc_pm_q), .simd_q(simd_q), .dm_ix(dm_ix)
);

// File: tb/test_bcast_load_unit.sv
module test_bcast_load_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we, mode_bc_dm, mode_bc_pm, mode_simd;
  logic        idx_we;
  logic [3:0]  idx_wsel;
  logic [31:0] idx_wdata;
  logic        dm_valid, pm_valid;
  logic [1:0]  dm_op, pm_op;
  logic [2:0]  dm_idx, pm_idx;
  logic [31:0] dm_mod, pm_mod, dm_data, pm_data, dm_ydata, pm_ydata;
  logic [3:0]  dm_dest, pm_dest;
  logic        rd_lane;
  logic [3:0]  rd_addr, idx_rsel;
  logic [31:0] rd_data, idx_rdata;
  logic        collide;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bcast_load_unit i_bcast_load_unit (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_bc_dm(mode_bc_dm), .mode_bc_pm(mode_bc_pm), .mode_simd(mode_simd),
    .idx_we(idx_we), .idx_wsel(idx_wsel), .idx_wdata(idx_wdata),
    .dm_valid(dm_valid), .dm_op(dm_op), .dm_idx(dm_idx), .dm_mod(dm_mod),
    .dm_dest(dm_dest), .dm_data(dm_data), .dm_ydata(dm_ydata),
    .pm_valid(pm_valid), .pm_op(pm_op), .pm_idx(pm_idx), .pm_mod(pm_mod),
    .pm_dest(pm_dest), .pm_data(pm_data), .pm_ydata(pm_ydata),
    .rd_lane(rd_lane), .rd_addr(rd_addr), .rd_data(rd_data),
    .idx_rsel(idx_rsel), .idx_rdata(idx_rdata), .collide(collide)
  );

  typedef struct packed {
    logic [23:0] rq;
    logic        simd, bcd, bcp;
    logic        dv;  logic [1:0] dop; logic [2:0] didx; logic [3:0] ddest; logic [31:0] ddat;
    logic        pv;  logic [1:0] pop; logic [2:0] pidx; logic [3:0] pdest; logic [31:0] pdat;
    logic [3:0]  chk;
    logic [31:0] ex, ey;
  } vec_t;

  localparam logic [31:0] DA = 32'hA5A5_0001, DB = 32'h5A5A_0002, DC = 32'hC3C3_0003;
  localparam logic [31:0] DD = 32'h0D0D_0004, DE = 32'hE0E0_0005;
  localparam logic [31:0] NDB = ~DB, NDC = ~DC;
  localparam int NV = 16;

  // complementary words are always the bitwise inverse of the loaded word
  localparam vec_t VECS [NV] = '{
    '{"R2 ",1'b0,1'b0,1'b0, 1'b1,2'd0,3'd5,4'd10,DE, 1'b1,2'd0,3'd3,4'd11,DA, 4'd11,DA,32'd0},
    '{"R3 ",1'b0,1'b1,1'b0, 1'b1,2'd0,3'd1,4'd3,DA,  1'b0,2'd0,3'd0,4'd0,32'd0, 4'd3,DA,DA},
    '{"R4 ",1'b0,1'b0,1'b0, 1'b1,2'd0,3'd1,4'd3,DA,  1'b0,2'd0,3'd0,4'd0,32'd0, 4'd3,DA,32'd0},
    '{"R4 ",1'b0,1'b1,1'b0, 1'b1,2'd0,3'd2,4'd3,DA,  1'b0,2'd0,3'd0,4'd0,32'd0, 4'd3,DA,32'd0},
    '{"R3 ",1'b0,1'b0,1'b1, 1'b0,2'd0,3'd0,4'd0,32'd0, 1'b1,2'd0,3'd1,4'd5,DB, 4'd5,DB,DB},
    '{"R4 ",1'b0,1'b1,1'b0, 1'b0,2'd0,3'd0,4'd0,32'd0, 1'b1,2'd0,3'd1,4'd5,DB, 4'd5,DB,32'd0},
    '{"R5 ",1'b0,1'b1,1'b0, 1'b1,2'd1,3'd1,4'd3,DA,  1'b0,2'd0,3'd0,4'd0,32'd0, 4'd3,32'd0,32'd0},
    '{"R5 ",1'b1,1'b0,1'b1, 1'b0,2'd0,3'd0,4'd0,32'd0, 1'b1,2'd2,3'd1,4'd5,DB, 4'd5,32'd0,32'd0},
    '{"R6 ",1'b1,1'b0,1'b0, 1'b1,2'd0,3'd2,4'd4,DC,  1'b0,2'd0,3'd0,4'd0,32'd0, 4'd4,DC,NDC},
    '{"R6 ",1'b1,1'b1,1'b0, 1'b1,2'd0,3'd1,4'd4,DC,  1'b0,2'd0,3'd0,4'd0,32'd0, 4'd4,DC,DC},
    '{"R6 ",1'b1,1'b0,1'b0, 1'b0,2'd0,3'd0,4'd0,32'd0, 1'b1,2'd0,3'd2,4'd12,DB, 4'd12,DB,NDB},
    '{"R7 ",1'b0,1'b1,1'b1, 1'b1,2'd0,3'd1,4'd6,DD,  1'b1,2'd0,3'd1,4'd7,DE, 4'd6,DD,DD},
    '{"R7 ",1'b0,1'b1,1'b1, 1'b1,2'd0,3'd1,4'd6,DD,  1'b1,2'd0,3'd1,4'd7,DE, 4'd7,DE,DE},
    '{"R7 ",1'b0,1'b1,1'b0, 1'b1,2'd0,3'd1,4'd6,DD,  1'b1,2'd0,3'd1,4'd7,DE, 4'd7,DE,32'd0},
    '{"R9 ",1'b0,1'b0,1'b1, 1'b1,2'd0,3'd1,4'd8,DD,  1'b1,2'd0,3'd1,4'd8,DE, 4'd8,DD,DE},
    '{"R9 ",1'b0,1'b1,1'b1, 1'b1,2'd0,3'd1,4'd8,DD,  1'b1,2'd0,3'd1,4'd8,DE, 4'd8,DD,DD}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_we = 0; mode_bc_dm = 0; mode_bc_pm = 0; mode_simd = 0;
    idx_we = 0; idx_wsel = 0; idx_wdata = 0;
    dm_valid = 0; dm_op = 0; dm_idx = 0; dm_mod = 0; dm_dest = 0; dm_data = 0; dm_ydata = 0;
    pm_valid = 0; pm_op = 0; pm_idx = 0; pm_mod = 0; pm_dest = 0; pm_data = 0; pm_ydata = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic set_mode(input logic s, input logic bd, input logic bp);
    @(negedge clk); mode_we = 1; mode_simd = s; mode_bc_dm = bd; mode_bc_pm = bp;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic read_rf(input logic lane, input logic [3:0] a, output logic [31:0] v);
    rd_lane = lane; rd_addr = a; #1 v = rd_data;
  endtask

  task automatic read_ix(input logic [3:0] s, output logic [31:0] v);
    idx_rsel = s; #1 v = idx_rdata;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(); rst_n = 0; rd_lane = 0; rd_addr = 0; idx_rsel = 0;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      set_mode(VECS[i].simd, VECS[i].bcd, VECS[i].bcp);
      @(negedge clk);
      dm_valid = VECS[i].dv; dm_op = VECS[i].dop; dm_idx = VECS[i].didx; dm_mod = 1;
      dm_dest = VECS[i].ddest; dm_data = VECS[i].ddat; dm_ydata = ~VECS[i].ddat;
      pm_valid = VECS[i].pv; pm_op = VECS[i].pop; pm_idx = VECS[i].pidx; pm_mod = 1;
      pm_dest = VECS[i].pdest; pm_data = VECS[i].pdat; pm_ydata = ~VECS[i].pdat;
      @(negedge clk);
      dm_valid = 0; pm_valid = 0;
      read_rf(1'b0, VECS[i].chk, v); chk($sformatf("%s lane X vec %0d", VECS[i].rq, i), v, VECS[i].ex);
      read_rf(1'b1, VECS[i].chk, v); chk($sformatf("%s lane Y vec %0d", VECS[i].rq, i), v, VECS[i].ey);
    end

    // R1: reset clears registers, index registers and mode bits
    set_mode(1'b1, 1'b1, 1'b1);
    @(negedge clk); idx_we = 1; idx_wsel = 4'd13; idx_wdata = 32'h77;
    @(negedge clk); idx_we = 0;
    do_reset();
    for (int a = 0; a < 16; a++) begin
      read_rf(1'b0, 4'(a), v); chk("R1 lane X clear", v, 32'd0);
      read_rf(1'b1, 4'(a), v); chk("R1 lane Y clear", v, 32'd0);
      read_ix(4'(a), v);       chk("R1 index clear", v, 32'd0);
    end
    @(negedge clk); dm_valid = 1; dm_op = 0; dm_idx = 1; dm_dest = 2; dm_data = DA; dm_ydata = ~DA;
    @(negedge clk); dm_valid = 0;
    read_rf(1'b1, 4'd2, v); chk("R1 mode bits cleared (no Y write)", v, 32'd0);

    // R8: post-modify once, broadcast adds no second step
    do_reset();
    set_mode(1'b0, 1'b1, 1'b1);
    @(negedge clk); idx_we = 1; idx_wsel = 4'd1; idx_wdata = 32'd100;
    @(negedge clk); idx_we = 0;
    dm_valid = 1; dm_op = 0; dm_idx = 1; dm_mod = 4; dm_dest = 9; dm_data = DB; dm_ydata = ~DB;
    pm_valid = 1; pm_op = 0; pm_idx = 1; pm_mod = 32'hFFFF_FFFF; pm_dest = 10; pm_data = DC; pm_ydata = ~DC;
    @(negedge clk); dm_valid = 0; pm_valid = 0;
    read_ix(4'd1, v); chk("R8 I1 post-modify once", v, 32'd104);
    read_ix(4'd9, v); chk("R8 I9 wraps modulo", v, 32'hFFFF_FFFF);
    @(negedge clk); pm_valid = 1; pm_op = 1; pm_idx = 3; pm_mod = 7;
    @(negedge clk); pm_valid = 0;
    read_ix(4'd11, v); chk("R8 system load post-modifies", v, 32'd7);
    read_ix(4'd3, v);  chk("R8 DM bank untouched by PM", v, 32'd0);

    // R10: direct write beats same-cycle post-modify
    @(negedge clk); idx_we = 1; idx_wsel = 4'd1; idx_wdata = 32'd50;
    dm_valid = 1; dm_op = 0; dm_idx = 1; dm_mod = 4; dm_dest = 9;
    @(negedge clk); idx_we = 0; dm_valid = 0;
    read_ix(4'd1, v); chk("R10 write wins", v, 32'd50);

    // R9: collide flag in the cycle of the conflict
    @(negedge clk);
    dm_valid = 1; dm_op = 0; dm_idx = 2; dm_dest = 14; dm_data = DD;
    pm_valid = 1; pm_op = 0; pm_idx = 2; pm_dest = 14; pm_data = DE;
    #1 chk("R9 collide high", {31'd0, collide}, 32'd1);
    pm_op = 2;
    #1 chk("R9 no collide with store", {31'd0, collide}, 32'd0);
    pm_op = 0; pm_dest = 15;
    #1 chk("R9 no collide distinct dest", {31'd0, collide}, 32'd0);
    @(negedge clk); dm_valid = 0; pm_valid = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule